// File: doc/BRIEF.md
# Interrupt Vector Dispatch Sequencer

This block turns one interrupt event into the fixed save-and-redirect sequence of a small 16-bit segmented processor core. An event comes from one of three sources: a software interrupt instruction that carries its own type number, a non-maskable line that always maps to type 2, or a maskable request line whose type is fetched from the interrupt controller through a two-pulse acknowledge handshake.

Once an event is accepted, the sequencer pushes the flags word, the code segment and the instruction pointer onto the stack. It writes the flags back to the core with trap and interrupt-enable cleared, and reports each new stack pointer value. It then reads the two halves of the vector entry at four times the type number and hands the new CS:IP to the fetch unit with a single done pulse. The core supplies the stack pointer. The vector memory answers each read one cycle after the read strobe.

Top module: `irq_dispatch_seq`

## Requirements
- R1: Events are accepted only while the block is idle (busy low). When more than one is present, a software request wins over a pending non-maskable event, and that event wins over the maskable line.
- R2: The maskable line is not accepted while bit 9 (interrupt enable) of `flags_in` is 0. It then has no effect on any output.
- R3: A maskable event drives `inta_n` low for one cycle, high for one cycle, then low for one cycle. The type is the value of `ack_data` in the cycle of the second low pulse. Software and non-maskable events never drive `inta_n` low.
- R4: A rising edge on `nmi_req` is remembered until it is serviced, including an edge that arrives while the block is busy. Its sequence uses type 2.
- R5: The block makes three stack writes in consecutive cycles: the flags at SP-2, the code segment at SP-4 and the instruction pointer at SP-6. SP is the value of `sp_in` when the event is accepted.
- R6: With each stack write, `sp_upd_en` is high and `sp_upd` equals that write's address.
- R7: In the cycle of the flags push, `flags_we` is high and `flags_wdata` equals the saved flags with bit 8 (trap) and bit 9 (interrupt enable) cleared.
- R8: After the pushes, the block reads the vector at byte address type*4, which returns the new IP, and then at type*4+2, which returns the new CS. Each read's data is taken from `mem_rd_data` in the cycle that follows its strobe.
- R9: `done` is a single-cycle pulse that comes two cycles after the second vector read strobe, with `new_cs` and `new_ip` valid. `busy` is high from the cycle after acceptance through the done cycle.
- R10: After reset the block is idle, `inta_n` is high and no write, read, flag-update or done strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swi_req | input | 1 | Software interrupt request, sampled while idle |
| swi_type | input | 8 | Type number of the software interrupt |
| nmi_req | input | 1 | Non-maskable line, edge sensitive |
| intr_req | input | 1 | Maskable request line, level sensitive |
| flags_in | input | 16 | Current flags word of the core |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| inta_n | output | 1 | Active-low interrupt acknowledge |
| ack_data | input | 8 | Low data byte driven by the interrupt controller |
| mem_wr_en | output | 1 | Stack write strobe |
| mem_wr_addr | output | 16 | Stack write byte address |
| mem_wr_data | output | 16 | Stack write word |
| sp_upd_en | output | 1 | Stack pointer update strobe |
| sp_upd | output | 16 | New stack pointer value |
| flags_we | output | 1 | Flags write-back strobe |
| flags_wdata | output | 16 | Flags with trap and interrupt enable cleared |
| mem_rd_en | output | 1 | Vector table read strobe |
| mem_rd_addr | output | 10 | Vector table byte address |
| mem_rd_data | input | 16 | Read word, valid the cycle after the strobe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | New CS:IP valid pulse |
| new_cs | output | 16 | Code segment from the vector |
| new_ip | output | 16 | Instruction pointer from the vector |

## Verification
On every cycle, the assertions check the following. Acknowledge, stack writes and vector reads never overlap. The grant is one-hot. Consecutive stack-pointer reports step down by two. The written-back flags always have trap and enable cleared. Done never lasts two cycles. Which event wins, the type each source yields, the order and addresses of the pushes, the byte sampled from the second acknowledge pulse, and the CS:IP returned can only be shown by the bench scenarios, whose cycle-accurate model is compared against all outputs on every clock.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ACK, ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP,
      ST_RD_IP, ST_RD_CS, ST_RD_WAIT, ST_DONE
   } seq_st_e;

   typedef enum logic [2:0] {
      AK_IDLE, AK_P1, AK_GAP, AK_P2, AK_FIN
   } ack_st_e;

   typedef enum logic [1:0] {
      SRC_NONE, SRC_SOFT, SRC_NMI, SRC_MASK
   } src_e;
endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
   import irq_dispatch_pkg::*;
#(
   parameter int DW       = 16,
   parameter int TYPE_W   = 8,
   parameter int NMI_TYPE = 2,
   parameter int IF_BIT   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic              swi_req,
   input  logic [TYPE_W-1:0] swi_type,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [DW-1:0]     flags_in,
   output logic              take,
   output src_e              src,
   output logic [TYPE_W-1:0] type_imm
);
   logic       nmi_prev, nmi_pend, nmi_rise, pend_now;
   logic [2:0] grant;

   assign nmi_rise = nmi_req & ~nmi_prev;
   assign pend_now = nmi_pend | nmi_rise;

   assign grant[0] = swi_req;
   assign grant[1] = pend_now & ~swi_req;
   assign grant[2] = intr_req & flags_in[IF_BIT] & ~swi_req & ~pend_now;

   assign take = idle & (|grant);

   always_comb begin
      if (grant[0])      src = SRC_SOFT;
      else if (grant[1]) src = SRC_NMI;
      else if (grant[2]) src = SRC_MASK;
      else               src = SRC_NONE;
   end

   assign type_imm = grant[0] ? swi_type : TYPE_W'(NMI_TYPE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_prev <= nmi_req;
         nmi_pend <= pend_now & ~(idle & grant[1]);
      end
   end

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_mask_needs_ie_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && src == SRC_MASK) |-> flags_in[IF_BIT]);
endmodule

// File: rtl/irq_ack_hs.sv
module irq_ack_hs
   import irq_dispatch_pkg::*;
#(
   parameter int TYPE_W    = 8,
   parameter int PULSE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TYPE_W-1:0] ack_data,
   output logic              inta_n,
   output logic              ack_done,
   output logic [TYPE_W-1:0] ack_type
);
   ack_st_e st;
   logic    last;

   initial begin : prm_chk
      assert (PULSE_CYC >= 1) else $error("PULSE_CYC must be at least 1");
   end

   generate
      if (PULSE_CYC > 1) begin : g_cnt
         localparam int CW = $clog2(PULSE_CYC);
         logic [CW-1:0] cnt;
         assign last = (cnt == CW'(PULSE_CYC - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (st == AK_IDLE || st == AK_FIN || last) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
      end else begin : g_one
         assign last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= AK_IDLE;
         ack_type <= '0;
      end else begin
         case (st)
            AK_IDLE: if (start) st <= AK_P1;
            AK_P1:   if (last) st <= AK_GAP;
            AK_GAP:  if (last) st <= AK_P2;
            AK_P2:   if (last) begin
                        st       <= AK_FIN;
                        ack_type <= ack_data;
                     end
            default: st <= AK_IDLE;
         endcase
      end
   end

   assign inta_n   = !(st == AK_P1 || st == AK_P2);
   assign ack_done = (st == AK_FIN);

   assert_ack_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (st == AK_IDLE));
   assert_ack_done_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |-> $past(!inta_n));
endmodule

// File: rtl/irq_seq_core.sv
module irq_seq_core
   import irq_dispatch_pkg::*;
#(
   parameter int DW     = 16,
   parameter int TYPE_W = 8,
   parameter int TF_BIT = 8,
   parameter int IF_BIT = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  src_e                src,
   input  logic [TYPE_W-1:0]   type_imm,
   input  logic [DW-1:0]       flags_in,
   input  logic [DW-1:0]       cs_in,
   input  logic [DW-1:0]       ip_in,
   input  logic [DW-1:0]       sp_in,
   input  logic                ack_done,
   input  logic [TYPE_W-1:0]   ack_type,
   input  logic [DW-1:0]       mem_rd_data,
   output logic                ack_start,
   output logic                idle,
   output logic                busy,
   output logic                mem_wr_en,
   output logic [DW-1:0]       mem_wr_addr,
   output logic [DW-1:0]       mem_wr_data,
   output logic                sp_upd_en,
   output logic [DW-1:0]       sp_upd,
   output logic                flags_we,
   output logic [DW-1:0]       flags_wdata,
   output logic                mem_rd_en,
   output logic [TYPE_W+1:0]   mem_rd_addr,
   output logic                done,
   output logic [DW-1:0]       new_cs,
   output logic [DW-1:0]       new_ip
);
   localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << TF_BIT) | (DW'(1) << IF_BIT));
   localparam logic [DW-1:0] WORD_B   = DW'(2);

   seq_st_e           st;
   logic [TYPE_W-1:0] typ;
   logic [DW-1:0]     fl_q, cs_q, ip_q, sp_q;
   logic              pushing;

   assign idle      = (st == ST_IDLE);
   assign busy      = !idle;
   assign ack_start = take && (src == SRC_MASK);
   assign pushing   = (st == ST_PUSH_FL) || (st == ST_PUSH_CS) || (st == ST_PUSH_IP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         typ    <= '0;
         fl_q   <= '0;
         cs_q   <= '0;
         ip_q   <= '0;
         sp_q   <= '0;
         new_cs <= '0;
         new_ip <= '0;
      end else begin
         if (pushing) sp_q <= sp_q - WORD_B;
         case (st)
            ST_IDLE: if (take) begin
               typ  <= type_imm;
               fl_q <= flags_in;
               cs_q <= cs_in;
               ip_q <= ip_in;
               sp_q <= sp_in;
               st   <= (src == SRC_MASK) ? ST_ACK : ST_PUSH_FL;
            end
            ST_ACK: if (ack_done) begin
               typ <= ack_type;
               st  <= ST_PUSH_FL;
            end
            ST_PUSH_FL: st <= ST_PUSH_CS;
            ST_PUSH_CS: st <= ST_PUSH_IP;
            ST_PUSH_IP: st <= ST_RD_IP;
            ST_RD_IP:   st <= ST_RD_CS;
            ST_RD_CS: begin
               new_ip <= mem_rd_data;
               st     <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               new_cs <= mem_rd_data;
               st     <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_wr_data = fl_q;
      if (st == ST_PUSH_CS)      mem_wr_data = cs_q;
      else if (st == ST_PUSH_IP) mem_wr_data = ip_q;
   end

   assign mem_wr_en   = pushing;
   assign mem_wr_addr = sp_q - WORD_B;
   assign sp_upd_en   = pushing;
   assign sp_upd      = sp_q - WORD_B;
   assign flags_we    = (st == ST_PUSH_FL);
   assign flags_wdata = fl_q & CLR_MASK;
   assign mem_rd_en   = (st == ST_RD_IP) || (st == ST_RD_CS);
   assign mem_rd_addr = {typ, (st == ST_RD_CS), 1'b0};
   assign done        = (st == ST_DONE);

   assert_sp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_upd_en && $past(sp_upd_en)) |-> (sp_upd == $past(sp_upd) - WORD_B));
   assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (!flags_wdata[TF_BIT] && !flags_wdata[IF_BIT]));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_read_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_addr[1]) |=> (mem_rd_en && mem_rd_addr[1]));
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
   import irq_dispatch_pkg::*;
#(
   parameter int DW        = 16,
   parameter int TYPE_W    = 8,
   parameter int NMI_TYPE  = 2,
   parameter int TF_BIT    = 8,
   parameter int IF_BIT    = 9,
   parameter int ACK_PULSE = 1,
   localparam int VA_W     = TYPE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swi_req,
   input  logic [TYPE_W-1:0] swi_type,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [DW-1:0]     flags_in,
   input  logic [DW-1:0]     cs_in,
   input  logic [DW-1:0]     ip_in,
   input  logic [DW-1:0]     sp_in,
   output logic              inta_n,
   input  logic [TYPE_W-1:0] ack_data,
   output logic              mem_wr_en,
   output logic [DW-1:0]     mem_wr_addr,
   output logic [DW-1:0]     mem_wr_data,
   output logic              sp_upd_en,
   output logic [DW-1:0]     sp_upd,
   output logic              flags_we,
   output logic [DW-1:0]     flags_wdata,
   output logic              mem_rd_en,
   output logic [VA_W-1:0]   mem_rd_addr,
   input  logic [DW-1:0]     mem_rd_data,
   output logic              busy,
   output logic              done,
   output logic [DW-1:0]     new_cs,
   output logic [DW-1:0]     new_ip
);
   initial begin : prm_chk
      assert (TF_BIT < DW && IF_BIT < DW && TF_BIT != IF_BIT)
         else $error("flag bit positions out of range");
      assert (NMI_TYPE < (1 << TYPE_W)) else $error("NMI_TYPE does not fit");
   end

   logic              idle, take, ack_start, ack_done;
   src_e              src;
   logic [TYPE_W-1:0] type_imm, ack_type;

   irq_src_arb #(.DW(DW), .TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE), .IF_BIT(IF_BIT)) arb_i (
      .clk(clk), .rst_n(rst_n), .idle(idle), .swi_req(swi_req), .swi_type(swi_type),
      .nmi_req(nmi_req), .intr_req(intr_req), .flags_in(flags_in),
      .take(take), .src(src), .type_imm(type_imm));

   irq_ack_hs #(.TYPE_W(TYPE_W), .PULSE_CYC(ACK_PULSE)) ack_i (
      .clk(clk), .rst_n(rst_n), .start(ack_start), .ack_data(ack_data),
      .inta_n(inta_n), .ack_done(ack_done), .ack_type(ack_type));

   irq_seq_core #(.DW(DW), .TYPE_W(TYPE_W), .TF_BIT(TF_BIT), .IF_BIT(IF_BIT)) core_i (
      .clk(clk), .rst_n(rst_n), .take(take), .src(src), .type_imm(type_imm),
      .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in),
      .ack_done(ack_done), .ack_type(ack_type), .mem_rd_data(mem_rd_data),
      .ack_start(ack_start), .idle(idle), .busy(busy),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .sp_upd_en(sp_upd_en), .sp_upd(sp_upd), .flags_we(flags_we),
      .flags_wdata(flags_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .done(done), .new_cs(new_cs), .new_ip(new_ip));

   assert_ack_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n |-> (!mem_wr_en && !mem_rd_en));
   assert_wr_rd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en && mem_rd_en));
   assert_push_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> busy);
endmodule

// File: tb/irq_dispatch_seq_tb_top.sv
module irq_dispatch_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        swi_req = 1'b0, nmi_req = 1'b0, intr_req = 1'b0;
   logic [7:0]  swi_type = '0, ack_data;
   logic [15:0] flags_in = 16'h0B2D, cs_in = 16'h1200, ip_in = 16'h0345, sp_in = 16'h8000;
   logic        inta_n, mem_wr_en, sp_upd_en, flags_we, mem_rd_en, busy, done;
   logic [15:0] mem_wr_addr, mem_wr_data, sp_upd, flags_wdata, mem_rd_data, new_cs, new_ip;
   logic [9:0]  mem_rd_addr;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [7:0] ack_val = 8'h48;
   int ack_falls = 0;
   int rd_log[$];

   always #5 clk = ~clk;

   irq_dispatch_seq dut_i (
      .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .swi_type(swi_type),
      .nmi_req(nmi_req), .intr_req(intr_req), .flags_in(flags_in), .cs_in(cs_in),
      .ip_in(ip_in), .sp_in(sp_in), .inta_n(inta_n), .ack_data(ack_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .sp_upd_en(sp_upd_en), .sp_upd(sp_upd), .flags_we(flags_we),
      .flags_wdata(flags_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .new_cs(new_cs),
      .new_ip(new_ip));

   function automatic logic [15:0] vec_word(input int a);
      return 16'((a * 37 + 16'h1234) & 16'hFFFF);
   endfunction

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= vec_word(int'(mem_rd_addr));

   // interrupt controller: junk on first acknowledge, type on second
   always @(negedge inta_n) ack_falls++;
   assign ack_data = (ack_falls % 2 == 0) ? ack_val : 8'hEE;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int ph = 0;
   logic [7:0]  m_t;
   logic [15:0] m_f, m_c, m_i, m_s;
   bit m_np = 0, m_nprev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_np = 0; m_nprev = 0;
      end else begin
         bit rise, pend;
         rise = nmi_req && !m_nprev;
         pend = m_np || rise;
         m_np = pend;
         if (ph == 0) begin
            if (swi_req || pend || (intr_req && flags_in[9])) begin
               m_f = flags_in; m_c = cs_in; m_i = ip_in; m_s = sp_in;
               if (swi_req) begin m_t = swi_type; ph = 5; end
               else if (pend) begin m_t = 8'd2; ph = 5; m_np = 0; end
               else ph = 1;
            end
         end else begin
            if (ph == 3) m_t = ack_data;
            if (ph == 8) rd_log.push_back(int'(m_t) * 4);
            ph = (ph == 11) ? 0 : ph + 1;
         end
         m_nprev = nmi_req;
      end
   end

   always @(negedge clk) if (rst_n && !finished) begin
      bit wr, rd;
      int wa, wd;
      chk(busy == (ph != 0), "R9 busy", busy, ph != 0);
      chk(inta_n == !(ph == 1 || ph == 3), "R3 inta_n", inta_n, !(ph == 1 || ph == 3));
      wr = (ph >= 5 && ph <= 7);
      chk(mem_wr_en == wr, "R5 wr_en", mem_wr_en, wr);
      if (wr) begin
         wa = int'(16'(m_s - 16'(2 * (ph - 4))));
         wd = (ph == 5) ? int'(m_f) : (ph == 6) ? int'(m_c) : int'(m_i);
         chk(mem_wr_addr == 16'(wa), "R5 wr_addr", mem_wr_addr, wa);
         chk(mem_wr_data == 16'(wd), "R5 wr_data", mem_wr_data, wd);
      end
      chk(sp_upd_en == wr, "R6 sp_upd_en", sp_upd_en, wr);
      if (wr) chk(sp_upd == 16'(wa), "R6 sp_upd", sp_upd, wa);
      chk(flags_we == (ph == 5), "R7 flags_we", flags_we, ph == 5);
      if (ph == 5) chk(flags_wdata == (m_f & 16'hFCFF), "R7 flags_wdata", flags_wdata, m_f & 16'hFCFF);
      rd = (ph == 8 || ph == 9);
      chk(mem_rd_en == rd, "R8 rd_en", mem_rd_en, rd);
      if (rd) chk(mem_rd_addr == 10'(m_t * 4 + (ph == 9 ? 2 : 0)), "R8 rd_addr",
                  mem_rd_addr, m_t * 4 + (ph == 9 ? 2 : 0));
      chk(done == (ph == 11), "R9 done", done, ph == 11);
      if (ph == 11) begin
         chk(new_ip == vec_word(m_t * 4), "R8 new_ip", new_ip, vec_word(m_t * 4));
         chk(new_cs == vec_word(m_t * 4 + 2), "R8 new_cs", new_cs, vec_word(m_t * 4 + 2));
      end
   end

   task automatic wait_idle();
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic drive_swi(input logic [7:0] t);
      @(negedge clk); #1 swi_req = 1; swi_type = t;
      @(negedge clk); #1 swi_req = 0;
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(inta_n && !busy && !mem_wr_en && !mem_rd_en && !flags_we && !done,
          "R10 reset outputs", {inta_n, busy, mem_wr_en, mem_rd_en, flags_we, done}, 6'b100000);
      #1 rst_n = 1;
      repeat (2) @(negedge clk);

      drive_swi(8'h21);                     // software type
      drive_swi(8'hFF);                     // top of table
      drive_swi(8'h00);                     // bottom of table

      // R4: non-maskable pulse uses type 2
      rd_log.delete();
      @(negedge clk); #1 nmi_req = 1;
      @(negedge clk); #1 nmi_req = 0;
      wait_idle();
      chk(rd_log.size() == 1 && rd_log[0] == 8, "R4 nmi type", rd_log.size() ? rd_log[0] : -1, 8);

      // R2: maskable blocked while enable clear
      flags_in = 16'h0925 & 16'hFDFF;
      @(negedge clk); #1 intr_req = 1;
      repeat (10) @(negedge clk);
      chk(!busy && inta_n, "R2 masked ignored", busy, 0);
      #1 intr_req = 0; flags_in = 16'h0B2D;

      // R3: maskable with acknowledge handshake
      rd_log.delete();
      ack_val = 8'h48; sp_in = 16'h0004;
      @(negedge clk); #1 intr_req = 1;
      @(negedge inta_n); @(negedge clk); #1 intr_req = 0;
      wait_idle();
      chk(rd_log.size() == 1 && rd_log[0] == 8'h48 * 4, "R3 acked type",
          rd_log.size() ? rd_log[0] : -1, 8'h48 * 4);

      // R1: all three together, software first then nmi then maskable
      rd_log.delete();
      ack_val = 8'h90; sp_in = 16'h7FF0;
      @(negedge clk); #1 swi_req = 1; swi_type = 8'h13; nmi_req = 1; intr_req = 1;
      @(negedge clk); #1 swi_req = 0; nmi_req = 0;
      @(negedge inta_n); @(negedge clk); #1 intr_req = 0;
      wait_idle();
      chk(rd_log.size() == 3, "R1 event count", rd_log.size(), 3);
      if (rd_log.size() == 3) begin
         chk(rd_log[0] == 8'h13 * 4, "R1 first soft", rd_log[0], 8'h13 * 4);
         chk(rd_log[1] == 8, "R1 second nmi", rd_log[1], 8);
         chk(rd_log[2] == 8'h90 * 4, "R1 third masked", rd_log[2], 8'h90 * 4);
      end

      // R4: edge during busy is remembered
      rd_log.delete();
      @(negedge clk); #1 swi_req = 1; swi_type = 8'h40;
      @(negedge clk); #1 swi_req = 0;
      repeat (3) @(negedge clk);
      #1 nmi_req = 1;
      @(negedge clk); #1 nmi_req = 0;
      wait_idle();
      wait_idle();
      chk(rd_log.size() == 2 && rd_log[1] == 8, "R4 latched edge",
          rd_log.size() == 2 ? rd_log[1] : -1, 8);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule